// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a purely combinational W-bit datapath unit that produces one result word per set of operands. It is built as W identical one-bit slices. Each slice holds a full adder, a bitwise logic cell and a four-way output selector.

Five control variables choose among fourteen microoperations: eight arithmetic, four logic and two single-bit shifts. These variables are the four-bit `sel` and `carry_in`. The upper two bits of `sel` pick the family of the result. The lower two bits, together with the carry input, pick the operation inside the arithmetic or logic family.

The arithmetic family always adds A, a term derived from B and the carry input. The term derived from B is one of zero, B, the complement of B, or all ones. The carries ripple from bit 0 to bit W-1. The unit holds no state, so a result is valid once the inputs have settled.

Top module: `shift_alu`

## Requirements
- R1: `sel[3:2]` selects the result family. The value 00 gives arithmetic, 01 gives logic, 10 gives a shift right of A, and 11 gives a shift left of A.
- R2: For arithmetic with `sel[1:0]`=00, `result` = A + `carry_in`. This is a transfer of A when the carry is 0 and an increment of A when the carry is 1.
- R3: For arithmetic with `sel[1:0]`=01, `result` = A + B + `carry_in`.
- R4: For arithmetic with `sel[1:0]`=10, `result` = A + ~B + `carry_in`. This is subtract-with-borrow when the carry is 0 and two's-complement A - B when the carry is 1.
- R5: For arithmetic with `sel[1:0]`=11, `result` = A + all-ones + `carry_in`. This is A - 1 when the carry is 0 and A when the carry is 1.
- R6: For logic, `sel[1:0]` selects the operation: 00 is A AND B, 01 is A OR B, 10 is A XOR B, and 11 is NOT A. `carry_in` has no effect on the result.
- R7: For a shift right, `result[i]` = A[i+1` ]` and `result[W-1]` = 0. `sel[1:0]`, `carry_in` and B have no effect.
- R8: For a shift left, `result[i]` = A[i-1] and `result[0]` = 0. `sel[1:0]`, `carry_in` and B have no effect.
- R9: `carry_out` equals bit W of the (W+1)-bit arithmetic sum when the arithmetic family is selected, and is 0 for the logic and shift families.
- R10: The carry ripples through every slice. For example, A = all ones with the transfer/increment operation and `carry_in` = 1 gives `result` = 0 and `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | Operand A |
| opb | input | W | Operand B |
| sel | input | 4 | Operation select; [3:2] family, [1:0] operation |
| carry_in | input | 1 | Carry into bit 0 |
| result | output | W | Operation result |
| carry_out | output | 1 | Carry out of the top slice, arithmetic family only |

## Verification
The bench drives all 32 values of the five control variables against operand pairs. These pairs include zero, all ones, alternating patterns and random words, and the expected values come from whole-word integer arithmetic.

The all-ones operand with a carry input catches a broken ripple chain: such a design would leave the upper bits set or drop the carry output. Shifts of all-ones catch a wrong fill bit, which would show up as a 1 in the vacated MSB or LSB. Shift operands with distinct neighbours catch swapped neighbour wiring.

Logic and shift operations are run with both carry values and all low select codes. A design that let the carry leak would change the result or raise `carry_out` outside the arithmetic family.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'b00,
        UNIT_LOGIC = 2'b01,
        UNIT_SHR   = 2'b10,
        UNIT_SHL   = 2'b11
    } unit_e;

    typedef enum logic [1:0] {
        BT_ZERO = 2'b00,
        BT_B    = 2'b01,
        BT_NOTB = 2'b10,
        BT_ONES = 2'b11
    } bterm_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'b00,
        LG_OR   = 2'b01,
        LG_XOR  = 2'b10,
        LG_NOTA = 2'b11
    } logic_op_e;

    typedef struct packed {
        logic sum;
        logic cout;
    } arith_bit_t;

endpackage

// File: rtl/alsu_arith_bit.sv
module alsu_arith_bit
    import alsu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic [1:0] mode,
    input  logic       cin,
    output logic       sum,
    output logic       cout
);
    logic       bterm_d;
    arith_bit_t res_d;

    // Operand-B conditioning selects the addend for this slice.
    always_comb begin
        unique case (bterm_e'(mode))
            BT_ZERO: bterm_d = 1'b0;
            BT_B:    bterm_d = b;
            BT_NOTB: bterm_d = ~b;
            default: bterm_d = 1'b1;
        endcase
    end

    // One full-adder cell.
    always_comb begin
        res_d.sum  = a ^ bterm_d ^ cin;
        res_d.cout = (a & bterm_d) | (cin & (a ^ bterm_d));
    end

    assign sum  = res_d.sum;
    assign cout = res_d.cout;
endmodule

// File: rtl/alsu_logic_bit.sv
module alsu_logic_bit
    import alsu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic [1:0] mode,
    output logic       y
);
    logic y_d;

    always_comb begin
        unique case (logic_op_e'(mode))
            LG_AND:  y_d = a & b;
            LG_OR:   y_d = a | b;
            LG_XOR:  y_d = a ^ b;
            default: y_d = ~a;
        endcase
    end

    assign y = y_d;
endmodule

// File: rtl/alsu_out_mux.sv
module alsu_out_mux
    import alsu_pkg::*;
(
    input  logic [1:0] unit,
    input  logic       arith_in,
    input  logic       logic_in,
    input  logic       shr_in,
    input  logic       shl_in,
    output logic       f
);
    logic f_d;

    always_comb begin
        unique case (unit_e'(unit))
            UNIT_ARITH: f_d = arith_in;
            UNIT_LOGIC: f_d = logic_in;
            UNIT_SHR:   f_d = shr_in;
            default:    f_d = shl_in;
        endcase
    end

    assign f = f_d;
endmodule

// File: rtl/shift_alu.sv
module shift_alu
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [3:0]   sel,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output logic         carry_out
);
    localparam int MSB = W - 1;

    logic [W:0]   carry_chain;
    logic [W-1:0] arith_d;
    logic [W-1:0] logic_d;
    logic [1:0]   unit_sel;
    logic [1:0]   op_sel;

    assign unit_sel       = sel[3:2];
    assign op_sel         = sel[1:0];
    assign carry_chain[0] = carry_in;

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic shr_src;
        logic shl_src;

        if (i == MSB) begin : g_top_fill
            assign shr_src = 1'b0;
        end else begin : g_top_nbr
            assign shr_src = opa[i+1];
        end

        if (i == 0) begin : g_bot_fill
            assign shl_src = 1'b0;
        end else begin : g_bot_nbr
            assign shl_src = opa[i-1];
        end

        alsu_arith_bit u_arith (
            .a    (opa[i]),
            .b    (opb[i]),
            .mode (op_sel),
            .cin  (carry_chain[i]),
            .sum  (arith_d[i]),
            .cout (carry_chain[i+1])
        );

        alsu_logic_bit u_logic (
            .a    (opa[i]),
            .b    (opb[i]),
            .mode (op_sel),
            .y    (logic_d[i])
        );

        alsu_out_mux u_mux (
            .unit     (unit_sel),
            .arith_in (arith_d[i]),
            .logic_in (logic_d[i]),
            .shr_in   (shr_src),
            .shl_in   (shl_src),
            .f        (result[i])
        );
    end

    assign carry_out = carry_chain[W] & (unit_e'(unit_sel) == UNIT_ARITH);

    // Guards on the assembled word, checked against whole-word arithmetic.
    always_comb begin
        if (unit_e'(unit_sel) == UNIT_SHR) begin
            p_shr_fill_r7: assert (result[MSB] == 1'b0 && result[MSB-1:0] == opa[MSB:1])
                else $error("shift right word mismatch");
        end
        if (unit_e'(unit_sel) == UNIT_SHL) begin
            p_shl_fill_r8: assert (result[0] == 1'b0 && result[MSB:1] == opa[MSB-1:0])
                else $error("shift left word mismatch");
        end
        if (unit_e'(unit_sel) != UNIT_ARITH) begin
            p_cout_quiet_r9: assert (carry_out == 1'b0)
                else $error("carry out raised outside arithmetic");
        end
        if (sel == 4'b0001) begin
            p_add_word_r3: assert ({carry_out, result} ==
                                   ({1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, carry_in}))
                else $error("addition word mismatch");
        end
        if (sel == 4'b0011 && carry_in) begin
            p_transfer_r5: assert (result == opa && carry_out)
                else $error("transfer through all-ones addend mismatch");
        end
        if (sel == 4'b0100) begin
            p_and_word_r6: assert (result == (opa & opb))
                else $error("AND word mismatch");
        end
    end
endmodule

// File: tb/tb_shift_alu.sv
module tb_shift_alu;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [3:0]   sel = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    shift_alu #(.W(W)) dut (
        .opa       (opa),
        .opb       (opb),
        .sel       (sel),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic string req_of(input logic [3:0] s);
        case (s[3:2])
            2'b00: case (s[1:0])
                2'b00:   return "R2";
                2'b01:   return "R3";
                2'b10:   return "R4";
                default: return "R5";
            endcase
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compute_ref(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic [3:0] s, input logic c,
                               output logic [W-1:0] f, output logic co);
        logic [W:0]   sum;
        logic [W-1:0] addend;
        case (s[1:0])
            2'b00:   addend = '0;
            2'b01:   addend = b;
            2'b10:   addend = ~b;
            default: addend = '1;
        endcase
        sum = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, c};
        co  = 1'b0;
        case (s[3:2])
            2'b00: begin f = sum[W-1:0]; co = sum[W]; end
            2'b01: case (s[1:0])
                2'b00:   f = a & b;
                2'b01:   f = a | b;
                2'b10:   f = a ^ b;
                default: f = ~a;
            endcase
            2'b10:   f = a >> 1;
            default: f = a << 1;
        endcase
    endtask

    task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic [3:0] s, input logic c, input string tag);
        logic [W-1:0] exp_f;
        logic         exp_co;
        @(posedge clk);
        opa = a; opb = b; sel = s; carry_in = c;
        compute_ref(a, b, s, c, exp_f, exp_co);
        @(negedge clk);
        checks++;
        if (result !== exp_f) begin
            errors++;
            $display("FAIL %s result sel=%b cin=%b a=%h b=%h actual=%h expected=%h",
                     tag, s, c, a, b, result, exp_f);
        end
        checks++;
        if (carry_out !== exp_co) begin
            errors++;
            $display("FAIL R9 carry_out sel=%b cin=%b a=%h b=%h actual=%b expected=%b",
                     s, c, a, b, carry_out, exp_co);
        end
    endtask

    initial begin
        logic [W-1:0] va [0:7];
        logic [W-1:0] vb [0:7];
        // Zero inputs at start: transfer of zero, no carry (R2, R1).
        @(negedge clk);
        checks++;
        if (result !== '0 || carry_out !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle state actual=%h/%b expected=00/0", result, carry_out);
        end
        // Full ripple through every slice (R10).
        apply_check('1, '0, 4'b0000, 1'b1, "R10");
        apply_check('1, 8'h01, 4'b0001, 1'b0, "R10");
        apply_check(8'h00, 8'h00, 4'b0011, 1'b0, "R10");
        va[0] = '0;    vb[0] = '0;
        va[1] = '1;    vb[1] = '1;
        va[2] = '1;    vb[2] = '0;
        va[3] = '0;    vb[3] = '1;
        va[4] = 8'hA5; vb[4] = 8'h5A;
        va[5] = 8'h80; vb[5] = 8'h01;
        va[6] = 8'h3C; vb[6] = 8'h3C;
        va[7] = 8'h01; vb[7] = 8'hFF;
        // Every select/carry combination (R1..R9).
        for (int code = 0; code < 32; code++) begin
            for (int v = 0; v < 8; v++)
                apply_check(va[v], vb[v], code[4:1], code[0], req_of(code[4:1]));
            for (int r = 0; r < 24; r++)
                apply_check(W'($urandom), W'($urandom), code[4:1], code[0],
                            req_of(code[4:1]));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule